// File: doc/BRIEF.md
# Multichannel TDM Frame Slot Sequencer

This block follows time-division-multiplexed frames on a serial port running in multichannel mode. It counts serial bit ticks (clock cycles where `sclk_en` is high). After a frame sync it waits a programmable number of ticks. It then walks through a programmable number of channel slots, each `SLOT_W` bits wide. On every data bit it raises `slot_active` and presents the slot index and the bit position within the slot.

The same block holds a loopback switch for a number of fixed port pairs. When loopback is on for a pair, the serial output of the port set as transmitter feeds the data input of the port set as receiver. Sequencing runs only while the multichannel enable is 1 and the operating-mode bit is 0. The delay and slot-count fields are captured while sequencing is off, and are held for as long as it runs.

Top module: `tdm_slot_seq`

## Requirements
- R1: `slot_active` stays 0 unless `mc_enable` is 1 and `op_mode` is 0.
- R2: With captured delay `d` (0 to 15), bit 0 of slot 0 falls on the `d`-th bit tick after the tick that carries `fsync`. With `d` = 0 it falls on the fsync tick itself.
- R3: The captured slot field `n` gives `n+1` slots per frame (1 to 128), with indices 0 to `n`, and exactly `(n+1)*SLOT_W` strobes per frame.
- R4: `bit_pos` runs from 0 to `SLOT_W-1` on successive strobes. After `SLOT_W-1` it returns to 0 and `slot_idx` advances by one.
- R5: After the final bit of the last slot, no strobe occurs until the next `fsync` tick, whatever the number of bit ticks.
- R6: An `fsync` tick during a frame or during its delay restarts the delay count and resets the slot index to 0.
- R7: `cfg_delay` and `cfg_slots` are captured only while sequencing is off. Changes made while it runs have no effect until the next enable.
- R8: Port pairs are (2k, 2k+1), and `port_dir` bit 1 means transmitter. With `lpbk_en[k]` set and the two ports of the pair in opposite directions, the receiver's `port_din` equals the transmitter's `port_dout`.
- R9: With `lpbk_en[k]` set and both ports of the pair in the same direction, both ports keep `port_din = port_pin`, and `lpbk_err[k]` is 1.
- R10: Loopback never reaches a port outside its own pair. With `lpbk_en[k]` clear, both ports of pair k see their pins and `lpbk_err[k]` is 0.
- R11: A strobe occurs only on a cycle with `sclk_en` high. While `slot_active` is 0, `slot_idx` and `bit_pos` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_enable | input | 1 | Multichannel enable |
| op_mode | input | 1 | Operating-mode bit; 1 blocks sequencing |
| cfg_delay | input | DELAY_W | Ticks from frame sync to first data bit |
| cfg_slots | input | CNT_W | Number of slots minus one |
| sclk_en | input | 1 | Serial bit tick |
| fsync | input | 1 | Frame sync, sampled on bit ticks |
| slot_active | output | 1 | High on each data bit of a slot |
| slot_idx | output | CNT_W | Current slot index |
| bit_pos | output | BIT_W | Bit position within the slot |
| lpbk_en | input | NPAIRS | Loopback enable, one per pair |
| port_dir | input | 2*NPAIRS | Port direction, 1 = transmit |
| port_dout | input | 2*NPAIRS | Serial output of each port |
| port_pin | input | 2*NPAIRS | External pin data of each port |
| port_din | output | 2*NPAIRS | Serial data presented to each port's receiver |
| lpbk_err | output | NPAIRS | Same-direction loopback flag, one per pair |

## Verification
The bench builds the block with `SLOT_W` = 4, the default 128-slot limit, a 4-bit delay and two port pairs. The narrow slot makes a full 128-slot frame only 512 ticks long, so the upper slot limit and the 15-tick delay limit both fit in the run. The same frames are driven both with and without idle cycles between ticks. Two pairs make it possible to observe that loopback on one pair leaves the other untouched.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SLOT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tdm_ctrl_shadow.sv
`timescale 1ns/1ps
module tdm_ctrl_shadow #(
  parameter int DELAY_W = 4,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0]   cfg_slots,
  output logic [DELAY_W-1:0] delay_q,
  output logic [CNT_W-1:0]   slots_q
);
  // Fields follow the inputs only while sequencing is off.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q <= '0;
      slots_q <= '0;
    end else if (!run) begin
      delay_q <= cfg_delay;
      slots_q <= cfg_slots;
    end
  end
endmodule

// File: rtl/tdm_slot_counter.sv
`timescale 1ns/1ps
module tdm_slot_counter
  import tdm_pkg::*;
#(
  parameter int SLOT_W  = 8,
  parameter int DELAY_W = 4,
  parameter int CNT_W   = 7,
  localparam int BIT_W  = $clog2(SLOT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               sclk_en,
  input  logic               fsync,
  input  logic [DELAY_W-1:0] delay_q,
  input  logic [CNT_W-1:0]   slots_q,
  output logic               slot_active,
  output logic [CNT_W-1:0]   slot_idx,
  output logic [BIT_W-1:0]   bit_pos,
  output logic               frame_last
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

  function automatic logic [BIT_W-1:0] step_bit(input logic [BIT_W-1:0] b);
    return (b == LAST_BIT) ? '0 : b + BIT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step_idx(input logic [CNT_W-1:0] i,
                                                 input logic [BIT_W-1:0] b);
    return (b == LAST_BIT) ? i + CNT_W'(1) : i;
  endfunction

  seq_state_e         state;
  logic [DELAY_W-1:0] dcnt;
  logic [CNT_W-1:0]   idx_q;
  logic [BIT_W-1:0]   bit_q;

  logic tick, start_now, delay_hit, in_slot, bit_now;
  logic [CNT_W-1:0] cur_idx;
  logic [BIT_W-1:0] cur_bit;

  always_comb begin
    tick      = run & sclk_en;
    start_now = tick & fsync & (delay_q == '0);
    delay_hit = tick & ~fsync & (state == ST_DELAY) & (dcnt == DELAY_W'(1));
    in_slot   = tick & ~fsync & (state == ST_SLOT);
    bit_now   = start_now | delay_hit | in_slot;
    cur_idx   = in_slot ? idx_q : '0;
    cur_bit   = in_slot ? bit_q : '0;
    frame_last = bit_now & (cur_bit == LAST_BIT) & (cur_idx == slots_q);
  end

  assign slot_active = bit_now;
  assign slot_idx    = bit_now ? cur_idx : '0;
  assign bit_pos     = bit_now ? cur_bit : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      state <= ST_WAIT;
      dcnt  <= '0;
      idx_q <= '0;
      bit_q <= '0;
    end else if (tick) begin
      if (bit_now) begin
        if (frame_last) begin
          state <= ST_WAIT;
          idx_q <= '0;
          bit_q <= '0;
        end else begin
          state <= ST_SLOT;
          idx_q <= step_idx(cur_idx, cur_bit);
          bit_q <= step_bit(cur_bit);
        end
      end else if (fsync) begin
        state <= ST_DELAY;
        dcnt  <= delay_q;
      end else if (state == ST_DELAY) begin
        dcnt <= dcnt - DELAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/tdm_loopback.sv
`timescale 1ns/1ps
module tdm_loopback #(
  parameter int NPAIRS = 2,
  localparam int NP    = 2 * NPAIRS
) (
  input  logic [NPAIRS-1:0] lpbk_en,
  input  logic [NP-1:0]     port_dir,
  input  logic [NP-1:0]     port_dout,
  input  logic [NP-1:0]     port_pin,
  output logic [NP-1:0]     port_din,
  output logic [NPAIRS-1:0] lpbk_err
);
  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    localparam int PA = 2 * k;
    localparam int PB = 2 * k + 1;
    logic opposite, linked;
    assign opposite     = port_dir[PA] ^ port_dir[PB];
    assign linked       = lpbk_en[k] & opposite;
    assign port_din[PA] = (linked & port_dir[PB]) ? port_dout[PB] : port_pin[PA];
    assign port_din[PB] = (linked & port_dir[PA]) ? port_dout[PA] : port_pin[PB];
    assign lpbk_err[k]  = lpbk_en[k] & ~opposite;
  end
endmodule

// File: rtl/tdm_slot_seq.sv
`timescale 1ns/1ps
module tdm_slot_seq #(
  parameter int SLOT_W    = 8,
  parameter int MAX_SLOTS = 128,
  parameter int DELAY_W   = 4,
  parameter int NPAIRS    = 2,
  localparam int CNT_W    = $clog2(MAX_SLOTS),
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int NP       = 2 * NPAIRS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mc_enable,
  input  logic               op_mode,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0]   cfg_slots,
  input  logic               sclk_en,
  input  logic               fsync,
  output logic               slot_active,
  output logic [CNT_W-1:0]   slot_idx,
  output logic [BIT_W-1:0]   bit_pos,
  input  logic [NPAIRS-1:0]  lpbk_en,
  input  logic [NP-1:0]      port_dir,
  input  logic [NP-1:0]      port_dout,
  input  logic [NP-1:0]      port_pin,
  output logic [NP-1:0]      port_din,
  output logic [NPAIRS-1:0]  lpbk_err
);
  logic               run;
  logic [DELAY_W-1:0] delay_q;
  logic [CNT_W-1:0]   slots_q;
  logic               frame_last;

  assign run = mc_enable & ~op_mode;

  tdm_ctrl_shadow #(.DELAY_W(DELAY_W), .CNT_W(CNT_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_delay(cfg_delay), .cfg_slots(cfg_slots),
    .delay_q(delay_q), .slots_q(slots_q)
  );

  tdm_slot_counter #(.SLOT_W(SLOT_W), .DELAY_W(DELAY_W), .CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk_en(sclk_en), .fsync(fsync),
    .delay_q(delay_q), .slots_q(slots_q),
    .slot_active(slot_active), .slot_idx(slot_idx), .bit_pos(bit_pos),
    .frame_last(frame_last)
  );

  tdm_loopback #(.NPAIRS(NPAIRS)) lpbk_i (
    .lpbk_en(lpbk_en), .port_dir(port_dir), .port_dout(port_dout),
    .port_pin(port_pin), .port_din(port_din), .lpbk_err(lpbk_err)
  );
endmodule

// File: rtl/tdm_slot_seq_chk.sv
`timescale 1ns/1ps
module tdm_slot_seq_chk #(
  parameter int SLOT_W  = 8,
  parameter int DELAY_W = 4,
  parameter int CNT_W   = 7,
  parameter int NPAIRS  = 2,
  localparam int BIT_W  = $clog2(SLOT_W),
  localparam int NP     = 2 * NPAIRS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               sclk_en,
  input logic               fsync,
  input logic               slot_active,
  input logic [CNT_W-1:0]   slot_idx,
  input logic [BIT_W-1:0]   bit_pos,
  input logic [DELAY_W-1:0] delay_q,
  input logic [CNT_W-1:0]   slots_q,
  input logic [NPAIRS-1:0]  lpbk_en,
  input logic [NP-1:0]      port_dir,
  input logic [NP-1:0]      port_dout,
  input logic [NP-1:0]      port_pin,
  input logic [NP-1:0]      port_din,
  input logic [NPAIRS-1:0]  lpbk_err
);
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !slot_active);

  p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sclk_en && fsync && delay_q == '0) |->
      (slot_active && slot_idx == '0 && bit_pos == '0));

  p_idx_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_active |-> (slot_idx <= slots_q));

  p_fields_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(delay_q) && $stable(slots_q)));

  p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_active |-> sclk_en);

  p_quiet_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_active |-> (slot_idx == '0 && bit_pos == '0));

  for (genvar k = 0; k < NPAIRS; k++) begin : g_pchk
    p_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lpbk_en[k] && port_dir[2*k] && !port_dir[2*k+1]) |->
        (port_din[2*k+1] == port_dout[2*k] && port_din[2*k] == port_pin[2*k]));

    p_same_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lpbk_err[k] |-> (port_din[2*k] == port_pin[2*k] &&
                       port_din[2*k+1] == port_pin[2*k+1]));

    p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lpbk_en[k] |-> (!lpbk_err[k] && port_din[2*k] == port_pin[2*k] &&
                       port_din[2*k+1] == port_pin[2*k+1]));
  end
endmodule

bind tdm_slot_seq tdm_slot_seq_chk #(
  .SLOT_W(SLOT_W), .DELAY_W(DELAY_W), .CNT_W(CNT_W), .NPAIRS(NPAIRS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .sclk_en(sclk_en), .fsync(fsync),
  .slot_active(slot_active), .slot_idx(slot_idx), .bit_pos(bit_pos),
  .delay_q(delay_q), .slots_q(slots_q), .lpbk_en(lpbk_en),
  .port_dir(port_dir), .port_dout(port_dout), .port_pin(port_pin),
  .port_din(port_din), .lpbk_err(lpbk_err)
);

// File: tb/tdm_slot_seq_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_seq_tb_top;
  localparam int SW = 4;
  localparam int MS = 128;
  localparam int DW = 4;
  localparam int NPR = 2;
  localparam int CW = $clog2(MS);
  localparam int BW = $clog2(SW);
  localparam int NP = 2 * NPR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_enable = 1'b0, op_mode = 1'b0;
  logic [DW-1:0] cfg_delay = '0;
  logic [CW-1:0] cfg_slots = '0;
  logic sclk_en = 1'b0, fsync = 1'b0;
  logic slot_active;
  logic [CW-1:0] slot_idx;
  logic [BW-1:0] bit_pos;
  logic [NPR-1:0] lpbk_en = '0;
  logic [NP-1:0] port_dir = '0, port_dout = '0, port_pin = '0;
  logic [NP-1:0] port_din;
  logic [NPR-1:0] lpbk_err;

  always #5 clk = ~clk;

  tdm_slot_seq #(.SLOT_W(SW), .MAX_SLOTS(MS), .DELAY_W(DW), .NPAIRS(NPR)) dut_i (
    .clk(clk), .rst_n(rst_n), .mc_enable(mc_enable), .op_mode(op_mode),
    .cfg_delay(cfg_delay), .cfg_slots(cfg_slots), .sclk_en(sclk_en), .fsync(fsync),
    .slot_active(slot_active), .slot_idx(slot_idx), .bit_pos(bit_pos),
    .lpbk_en(lpbk_en), .port_dir(port_dir), .port_dout(port_dout),
    .port_pin(port_pin), .port_din(port_din), .lpbk_err(lpbk_err)
  );

  typedef struct { int tk; int idx; int bp; } exp_t;
  exp_t sb_q[$];
  int checks = 0, fails = 0;
  int drv_tick = 0, mon_tick = 0, unexpected = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: compare each strobe with the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && sclk_en) begin
      if (slot_active) begin
        if (sb_q.size() == 0) begin
          unexpected++;
          check(1'b0, "R5 strobe with nothing expected", mon_tick, -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tk == mon_tick, "R2 R6 strobe tick", mon_tick, e.tk);
          check(e.idx == int'(slot_idx), "R3 slot index", int'(slot_idx), e.idx);
          check(e.bp == int'(bit_pos), "R4 bit position", int'(bit_pos), e.bp);
        end
      end
    end
    if (rst_n && !sclk_en && slot_active)
      check(1'b0, "R11 strobe without tick", 1, 0);
    if (sclk_en) mon_tick++;
  end

  task automatic cyc(input logic en, input logic fs);
    @(posedge clk); #1;
    sclk_en = en;
    fsync = fs;
    if (en) drv_tick++;
  endtask

  task automatic setup(input int d, input int n);
    cyc(0, 0);
    mc_enable = 1'b0;
    cfg_delay = DW'(d);
    cfg_slots = CW'(n - 1);
    cyc(0, 0);
    cyc(0, 0);
    mc_enable = 1'b1;
  endtask

  // Driver: model d, n, optional restart sync, optional idle gaps.
  task automatic run_seq(input int d, input int n, input int total,
                         input int restart, input bit gap);
    for (int k = 0; k < total; k++) begin
      bit fs;
      int s, off;
      fs = (k == 0) || (restart > 0 && k == restart);
      s = (restart > 0 && k >= restart) ? restart : 0;
      off = k - s - d;
      if (off >= 0 && off < n * SW) begin
        exp_t e;
        e.tk = drv_tick; e.idx = off / SW; e.bp = off % SW;
        sb_q.push_back(e);
      end
      cyc(1, fs);
      if (gap && (k % 3 == 2)) cyc(0, 0);
    end
    for (int k = 0; k < 6; k++) cyc(1, 0);
    cyc(0, 0);
    cyc(0, 0);
    check(sb_q.size() == 0, "R3 R5 all expected strobes seen", sb_q.size(), 0);
  endtask

  function automatic logic exp_din(input int p);
    int k, o;
    k = p / 2;
    o = (p % 2 == 0) ? p + 1 : p - 1;
    if (lpbk_en[k] && !port_dir[p] && port_dir[o]) return port_dout[o];
    return port_pin[p];
  endfunction

  task automatic lb_case(input logic [NPR-1:0] en, input logic [NP-1:0] dir,
                         input logic [NP-1:0] dout, input logic [NP-1:0] pin,
                         input string req);
    @(posedge clk); #1;
    lpbk_en = en; port_dir = dir; port_dout = dout; port_pin = pin;
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(port_din[p] == exp_din(p), req, int'(port_din[p]), int'(exp_din(p)));
    for (int k = 0; k < NPR; k++) begin
      logic ee;
      ee = lpbk_en[k] & (port_dir[2*k] == port_dir[2*k+1]);
      check(lpbk_err[k] == ee, req, int'(lpbk_err[k]), int'(ee));
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(slot_active == 1'b0, "R1 reset strobe low", int'(slot_active), 0);
    check(slot_idx == '0 && bit_pos == '0, "R11 reset position zero",
          int'(slot_idx), 0);
    check(lpbk_err == '0, "R10 reset error flags", int'(lpbk_err), 0);

    // R2 R3 R4: zero delay, three slots, with and without gaps
    setup(0, 3);  run_seq(0, 3, 16, 0, 1'b1);
    setup(0, 3);  run_seq(0, 3, 16, 0, 1'b0);
    // R2: mid and maximum delay
    setup(5, 2);  run_seq(5, 2, 16, 0, 1'b1);
    setup(15, 1); run_seq(15, 1, 22, 0, 1'b0);
    // R3: single slot and maximum slot count
    setup(1, 1);  run_seq(1, 1, 8, 0, 1'b0);
    setup(1, 128); run_seq(1, 128, 515, 0, 1'b0);
    // R6: restart during a slot and during the delay
    setup(2, 4);  run_seq(2, 4, 30, 10, 1'b1);
    setup(6, 2);  run_seq(6, 2, 20, 3, 1'b0);
    setup(0, 4);  run_seq(0, 4, 24, 7, 1'b0);

    // R5: ticks after the frame end with no sync produce no strobe
    setup(0, 1);  run_seq(0, 1, 4, 0, 1'b0);
    for (int k = 0; k < 20; k++) cyc(1, 0);
    cyc(0, 0);
    check(unexpected == 0, "R5 quiet after last slot", unexpected, 0);

    // R7: fields changed while running are ignored until next enable
    setup(3, 2);
    cyc(0, 0);
    cfg_delay = DW'(0);
    cfg_slots = CW'(4);
    cyc(0, 0);
    run_seq(3, 2, 14, 0, 1'b0);
    mc_enable = 1'b0;
    cyc(0, 0); cyc(0, 0);
    mc_enable = 1'b1;
    run_seq(0, 5, 24, 0, 1'b0);   // R7 new values take effect

    // R1: operating-mode bit or enable low block sequencing
    op_mode = 1'b1;
    cfg_delay = '0; cfg_slots = CW'(3);
    for (int k = 0; k < 12; k++) cyc(1, (k % 5) == 0);
    op_mode = 1'b0;
    mc_enable = 1'b0;
    for (int k = 0; k < 12; k++) cyc(1, (k % 5) == 0);
    cyc(0, 0);
    check(unexpected == 0, "R1 no strobe while gated", unexpected, 0);

    // R8 R9 R10: loopback pairs
    lb_case(2'b01, 4'b0001, 4'b0001, 4'b0000, "R8 pair0 port0 transmits");
    lb_case(2'b01, 4'b0010, 4'b0010, 4'b0101, "R8 pair0 port1 transmits");
    lb_case(2'b10, 4'b0100, 4'b0100, 4'b1001, "R8 pair1 port2 transmits");
    lb_case(2'b01, 4'b0011, 4'b0011, 4'b0001, "R9 same direction transmit");
    lb_case(2'b11, 4'b0000, 4'b1111, 4'b1010, "R9 same direction receive");
    lb_case(2'b00, 4'b0101, 4'b1111, 4'b0000, "R10 loopback off");
    lb_case(2'b01, 4'b0001, 4'b0101, 4'b1000, "R10 no cross into pair1");
    @(negedge clk);
    check(port_din[3:2] == 2'b10, "R10 pair1 pins untouched", int'(port_din[3:2]), 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule